// File: doc/BRIEF.md
# Complementary Dead-Time Inserter

This block sits after the waveform generator of a PWM channel and turns its raw A waveform into a pair of gate-drive signals with a programmed gap between them. It has two delay paths. The rising-delay path drives the A output: it holds that output at its idle (low) level until the A input has stayed high for a programmed number of time-base ticks. The falling-delay path drives the B output: it holds that output at its idle (high) level until the A input has stayed low for its own programmed number of ticks. Ticks are the cycles in which the time-base clock enable is high, so the dead time follows the time-base divider setting.

Each path has its own enable and its own output inversion. A disabled path passes its bypass input straight through: A for the rising-delay path, B for the falling-delay path. The inversion still applies to a disabled path. If both paths are enabled and only the falling-delay path is inverted, the outputs form a complementary pair. A gap then appears at both switching edges.

Each delay count has a shadow stage. With shadowing on, a write lands in the shadow and moves to the active count on the next counter-zero strobe. With shadowing off, a write reaches the active count at the next clock edge.

Top module: `deadband_gen`

## Requirements
- R1: After reset both active delay counts are zero, so with both paths enabled and no inversion, gate_a equals pwm_a_in and gate_b equals pwm_a_in in the same cycle.
- R2: With the rising-delay path enabled and active count N, gate_a (before inversion) first goes high after N clock edges with tb_tick high while pwm_a_in is high. It goes low in the same cycle that pwm_a_in goes low.
- R3: With the falling-delay path enabled and active count N, gate_b (before inversion) first goes low after N clock edges with tb_tick high while pwm_a_in is low. It goes high in the same cycle that pwm_a_in goes high.
- R4: A pulse of pwm_a_in that lasts fewer ticks than the path's count never appears at that path's output. This applies to high pulses on the rising-delay path and to low pulses on the falling-delay path.
- R5: A disabled rising-delay path gives gate_a = pwm_a_in, and a disabled falling-delay path gives gate_b = pwm_b_in, each without delay.
- R6: When a path's invert input is 1, that path's output is inverted, whether the path is enabled or disabled.
- R7: With shadowing on, a write (wr high with wdata) does not change the delay in use until a ctr_zero strobe, and after the strobe the written value is in use.
- R8: With shadowing off, a write is in use from the clock edge that samples it.
- R9: Clock edges with tb_tick low do not advance a delay, and the output does not move while they last.
- R10: With both paths enabled, red_inv = 0 and fed_inv = 1, gate_a and gate_b are never high together. Both outputs are low for the rising count after each rising edge of pwm_a_in and for the falling count after each falling edge.
- R11: If a shadowed write and a ctr_zero strobe fall in the same cycle, the active count takes the previous shadow value, and the new value waits for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tb_tick | input | 1 | Time-base clock enable; one tick per high cycle |
| ctr_zero | input | 1 | Time-base counter-zero strobe (shadow transfer) |
| pwm_a_in | input | 1 | Raw A waveform; source of both delay paths |
| pwm_b_in | input | 1 | Raw B waveform; bypass for a disabled falling-delay path |
| red_en | input | 1 | Enable for the rising-delay path |
| red_inv | input | 1 | Inversion for the gate_a output |
| red_shadow_en | input | 1 | Shadowing for the rising delay count |
| red_wr | input | 1 | Write strobe for the rising delay count |
| red_wdata | input | DLY_W | Rising delay count, in ticks |
| fed_en | input | 1 | Enable for the falling-delay path |
| fed_inv | input | 1 | Inversion for the gate_b output |
| fed_shadow_en | input | 1 | Shadowing for the falling delay count |
| fed_wr | input | 1 | Write strobe for the falling delay count |
| fed_wdata | input | DLY_W | Falling delay count, in ticks |
| gate_a | output | 1 | Final A drive signal |
| gate_b | output | 1 | Final B drive signal |

## Verification
The assertions check these properties on every cycle: the immediate return to the idle level on each enabled path, the bypass-with-inversion on each disabled path, and that the two outputs never overlap in complementary mode. They also check that a shadowed count holds without a zero strobe and that an unshadowed write lands one edge later. The actual delay lengths can only be shown by the bench's scenarios, which time them in ticks from the ports. The same is true of swallowed short pulses, stalls while tb_tick is low, and the order in which the shadow moves when a write and a zero strobe coincide.

// File: rtl/db_pkg.sv
// Shared types for the dead-time inserter.
// Assumes: nothing beyond standard SystemVerilog.
package db_pkg;
    // Which edge of the source a delay path holds back.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } db_edge_e;
endpackage

// File: rtl/db_cnt_reg.sv
// Delay count holder with an optional shadow stage.
// A write goes into the shadow. It also goes into the active count when
// shadowing is off. With shadowing on, ctr_zero moves the shadow into the
// active count. Assumes wr and ctr_zero are single-cycle strobes.
module db_cnt_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sh_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ctr_zero,
    output logic [W-1:0] act
);
    logic [W-1:0] shadow_q;

    // Shadow stage: captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow_q <= '0;
        else if (wr) shadow_q <= wdata;
    end

    // Active count: direct write when unshadowed, transfer at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                  act <= '0;
        else if (wr && !sh_en)       act <= wdata;
        else if (ctr_zero && sh_en)  act <= shadow_q;
    end
endmodule

// File: rtl/db_edge_delay.sv
// Single-edge delay. It holds the output at IDLE until the input has been at
// the non-idle level for dly ticks. A return to IDLE passes through at once,
// so a pulse shorter than dly ticks is dropped.
// Assumes tick is a clock enable sampled on clk.
module db_edge_delay
    import db_pkg::*;
#(
    parameter int       W    = 10,
    parameter db_edge_e KIND = EDGE_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         din,
    input  logic [W-1:0] dly,
    output logic         dout
);
    localparam logic         IDLE = (KIND == EDGE_RISE) ? 1'b0 : 1'b1;
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         qualified;

    // Counts ticks spent at the non-idle level; saturates; clears at idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (din == IDLE)           cnt_q <= '0;
        else if (tick && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end

    // The output leaves IDLE only once the hold time has elapsed.
    always_comb begin
        qualified = (din != IDLE) && (cnt_q >= dly);
        dout      = qualified ? ~IDLE : IDLE;
    end
endmodule

// File: rtl/db_path.sv
// One delay path: count register, edge delay, bypass select and polarity.
// Assumes src and byp are synchronous to clk.
module db_path
    import db_pkg::*;
#(
    parameter int       W    = 10,
    parameter db_edge_e KIND = EDGE_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctr_zero,
    input  logic         src,
    input  logic         byp,
    input  logic         en,
    input  logic         inv,
    input  logic         sh_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act,
    output logic         dout
);
    logic delayed;

    db_cnt_reg #(.W(W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_en    (sh_en),
        .wr       (wr),
        .wdata    (wdata),
        .ctr_zero (ctr_zero),
        .act      (act)
    );

    db_edge_delay #(.W(W), .KIND(KIND)) dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .din   (src),
        .dly   (act),
        .dout  (delayed)
    );

    // Bypass when disabled; polarity applies in both cases.
    always_comb dout = (en ? delayed : byp) ^ inv;
endmodule

// File: rtl/deadband_gen.sv
// Dead-time inserter top. The rising-delay path drives gate_a and the
// falling-delay path drives gate_b. Both take pwm_a_in as their source.
// Assumes all inputs are synchronous to clk and that tb_tick marks time-base ticks.
module deadband_gen
    import db_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  logic             ctr_zero,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    input  logic             red_en,
    input  logic             red_inv,
    input  logic             red_shadow_en,
    input  logic             red_wr,
    input  logic [DLY_W-1:0] red_wdata,
    input  logic             fed_en,
    input  logic             fed_inv,
    input  logic             fed_shadow_en,
    input  logic             fed_wr,
    input  logic [DLY_W-1:0] fed_wdata,
    output logic             gate_a,
    output logic             gate_b
);
    localparam int NPATH = 2;

    logic [NPATH-1:0]            p_byp, p_en, p_inv, p_sh, p_wr, p_out;
    logic [NPATH-1:0][DLY_W-1:0] p_wdata, p_act;
    logic [DLY_W-1:0]            red_act, fed_act;

    // Gather per-path configuration: index 0 rising, index 1 falling.
    always_comb begin
        p_byp   = {pwm_b_in, pwm_a_in};
        p_en    = {fed_en, red_en};
        p_inv   = {fed_inv, red_inv};
        p_sh    = {fed_shadow_en, red_shadow_en};
        p_wr    = {fed_wr, red_wr};
        p_wdata = {fed_wdata, red_wdata};
    end

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        localparam db_edge_e K = (g == 0) ? EDGE_RISE : EDGE_FALL;
        db_path #(.W(DLY_W), .KIND(K)) path_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tb_tick),
            .ctr_zero (ctr_zero),
            .src      (pwm_a_in),
            .byp      (p_byp[g]),
            .en       (p_en[g]),
            .inv      (p_inv[g]),
            .sh_en    (p_sh[g]),
            .wr       (p_wr[g]),
            .wdata    (p_wdata[g]),
            .act      (p_act[g]),
            .dout     (p_out[g])
        );
    end

    // Map path outputs to the drive pins.
    always_comb begin
        gate_a  = p_out[0];
        gate_b  = p_out[1];
        red_act = p_act[0];
        fed_act = p_act[1];
    end
endmodule

// File: rtl/deadband_gen_chk.sv
// Property checker for deadband_gen, attached by bind below.
module deadband_gen_chk #(
    parameter int DLY_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctr_zero,
    input logic             pwm_a_in,
    input logic             pwm_b_in,
    input logic             red_en,
    input logic             red_inv,
    input logic             red_shadow_en,
    input logic             red_wr,
    input logic [DLY_W-1:0] red_wdata,
    input logic             fed_en,
    input logic             fed_inv,
    input logic             fed_shadow_en,
    input logic             fed_wr,
    input logic [DLY_W-1:0] fed_wdata,
    input logic             gate_a,
    input logic             gate_b,
    input logic [DLY_W-1:0] red_act,
    input logic [DLY_W-1:0] fed_act
);
    // R2
    red_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_en && !pwm_a_in) |-> (gate_a == red_inv));
    // R3
    fed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fed_en && pwm_a_in) |-> (gate_b == !fed_inv));
    // R5
    red_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !red_en |-> (gate_a == (pwm_a_in ^ red_inv)));
    // R6
    fed_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fed_en |-> (gate_b == (pwm_b_in ^ fed_inv)));
    // R7
    red_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_shadow_en && !ctr_zero) |=> $stable(red_act));
    // R7
    fed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fed_shadow_en && !ctr_zero) |=> $stable(fed_act));
    // R8
    red_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!red_shadow_en && red_wr) |=> (red_act == $past(red_wdata)));
    // R8
    fed_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fed_shadow_en && fed_wr) |=> (fed_act == $past(fed_wdata)));
    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_en && fed_en && !red_inv && fed_inv) |-> !(gate_a && gate_b));
endmodule

bind deadband_gen deadband_gen_chk #(.DLY_W(DLY_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctr_zero      (ctr_zero),
    .pwm_a_in      (pwm_a_in),
    .pwm_b_in      (pwm_b_in),
    .red_en        (red_en),
    .red_inv       (red_inv),
    .red_shadow_en (red_shadow_en),
    .red_wr        (red_wr),
    .red_wdata     (red_wdata),
    .fed_en        (fed_en),
    .fed_inv       (fed_inv),
    .fed_shadow_en (fed_shadow_en),
    .fed_wr        (fed_wr),
    .fed_wdata     (fed_wdata),
    .gate_a        (gate_a),
    .gate_b        (gate_b),
    .red_act       (red_act),
    .fed_act       (fed_act)
);

// File: tb/deadband_gen_tb_top.sv
// Directed bench for deadband_gen: one task per scenario, timing in ticks.
module deadband_gen_tb_top;
    localparam int CLK_P = 10;
    localparam int W     = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tb_tick = 1'b1, ctr_zero = 1'b0;
    logic         pwm_a_in = 1'b0, pwm_b_in = 1'b0;
    logic         red_en = 1'b1, red_inv = 1'b0, red_shadow_en = 1'b0, red_wr = 1'b0;
    logic         fed_en = 1'b1, fed_inv = 1'b0, fed_shadow_en = 1'b0, fed_wr = 1'b0;
    logic [W-1:0] red_wdata = '0, fed_wdata = '0;
    logic         gate_a, gate_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    deadband_gen #(.DLY_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .ctr_zero(ctr_zero),
        .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .red_en(red_en), .red_inv(red_inv), .red_shadow_en(red_shadow_en),
        .red_wr(red_wr), .red_wdata(red_wdata),
        .fed_en(fed_en), .fed_inv(fed_inv), .fed_shadow_en(fed_shadow_en),
        .fed_wr(fed_wr), .fed_wdata(fed_wdata),
        .gate_a(gate_a), .gate_b(gate_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write a delay count; fed selects the path; zero raises ctr_zero alongside.
    task automatic wr_cnt(input bit fed, input int v, input bit zero);
        @(negedge clk);
        if (fed) begin fed_wr = 1'b1; fed_wdata = W'(v); end
        else     begin red_wr = 1'b1; red_wdata = W'(v); end
        ctr_zero = zero;
        @(negedge clk);
        red_wr = 1'b0; fed_wr = 1'b0; ctr_zero = 1'b0;
    endtask

    task automatic pulse_zero();
        @(negedge clk); ctr_zero = 1'b1;
        @(negedge clk); ctr_zero = 1'b0;
    endtask

    // Counts negedges until the chosen output reaches lvl (200 max).
    task automatic count_until(input bit sel_b, input logic lvl, output int n);
        n = 0;
        #1;
        while (((sel_b ? gate_b : gate_a) !== lvl) && n < 200) begin
            @(negedge clk); #1; n++;
        end
    endtask

    task automatic meas_a_rise(output int n);
        @(negedge clk); pwm_a_in = 1'b0;
        repeat (2) @(negedge clk);
        pwm_a_in = 1'b1;
        count_until(1'b0, 1'b1, n);
    endtask

    task automatic meas_b_fall(output int n);
        @(negedge clk); pwm_a_in = 1'b1;
        repeat (2) @(negedge clk);
        pwm_a_in = 1'b0;
        count_until(1'b1, 1'b0, n);
    endtask

    task automatic t_reset();
        int n;
        #1;
        chk("R1 gate_a in reset", int'(gate_a), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        meas_a_rise(n); chk("R1 rise delay after reset", n, 0);
        meas_b_fall(n); chk("R1 fall delay after reset", n, 0);
    endtask

    task automatic t_red();
        int n;
        wr_cnt(1'b0, 3, 1'b0);
        meas_a_rise(n); chk("R2 R8 rising delay", n, 3);
        repeat (2) @(negedge clk);
        pwm_a_in = 1'b0; #1;
        chk("R2 immediate drop", int'(gate_a), 0);
    endtask

    task automatic t_fed();
        int n;
        wr_cnt(1'b1, 5, 1'b0);
        meas_b_fall(n); chk("R3 falling delay", n, 5);
        repeat (2) @(negedge clk);
        pwm_a_in = 1'b1; #1;
        chk("R3 immediate rise", int'(gate_b), 1);
    endtask

    task automatic t_swallow();
        int seen = 0;
        wr_cnt(1'b0, 4, 1'b0);
        wr_cnt(1'b1, 4, 1'b0);
        @(negedge clk); pwm_a_in = 1'b0;
        repeat (6) @(negedge clk);
        pwm_a_in = 1'b1;
        for (int i = 0; i < 3; i++) begin #1; seen |= int'(gate_a); @(negedge clk); end
        pwm_a_in = 1'b0;
        for (int i = 0; i < 3; i++) begin #1; seen |= int'(gate_a); @(negedge clk); end
        chk("R4 short high pulse dropped", seen, 0);
        seen = 0;
        pwm_a_in = 1'b1;
        repeat (6) @(negedge clk);
        pwm_a_in = 1'b0;
        for (int i = 0; i < 2; i++) begin #1; seen |= int'(!gate_b); @(negedge clk); end
        pwm_a_in = 1'b1;
        for (int i = 0; i < 3; i++) begin #1; seen |= int'(!gate_b); @(negedge clk); end
        chk("R4 short low pulse dropped", seen, 0);
    endtask

    task automatic t_tick_stall();
        int n;
        wr_cnt(1'b0, 3, 1'b0);
        @(negedge clk); pwm_a_in = 1'b0;
        repeat (2) @(negedge clk);
        tb_tick = 1'b0; pwm_a_in = 1'b1;
        repeat (10) @(negedge clk);
        #1; chk("R9 no progress without tick", int'(gate_a), 0);
        tb_tick = 1'b1;
        count_until(1'b0, 1'b1, n);
        chk("R9 delay counts ticks only", n, 3);
    endtask

    task automatic t_bypass();
        red_en = 1'b0; fed_en = 1'b0;
        for (int inv = 0; inv < 2; inv++) begin
            red_inv = inv[0]; fed_inv = inv[0];
            for (int p = 0; p < 4; p++) begin
                @(negedge clk); pwm_a_in = p[0]; pwm_b_in = p[1]; #1;
                chk(inv ? "R6 bypass A inverted" : "R5 bypass A", int'(gate_a), p[0] ^ inv);
                chk(inv ? "R6 bypass B inverted" : "R5 bypass B", int'(gate_b), p[1] ^ inv);
            end
        end
        red_en = 1'b1; fed_en = 1'b1; red_inv = 1'b0; fed_inv = 1'b0;
    endtask

    task automatic t_pol_enabled();
        int n;
        wr_cnt(1'b0, 2, 1'b0);
        red_inv = 1'b1;
        @(negedge clk); pwm_a_in = 1'b0;
        repeat (2) @(negedge clk);
        #1; chk("R6 inverted idle", int'(gate_a), 1);
        @(negedge clk); pwm_a_in = 1'b1;
        count_until(1'b0, 1'b0, n);
        chk("R6 inverted delayed edge", n, 2);
        red_inv = 1'b0;
    endtask

    task automatic t_shadow();
        int n;
        wr_cnt(1'b0, 2, 1'b0);
        red_shadow_en = 1'b1;
        wr_cnt(1'b0, 6, 1'b0);
        meas_a_rise(n); chk("R7 held before zero", n, 2);
        pulse_zero();
        meas_a_rise(n); chk("R7 loaded at zero", n, 6);
        wr_cnt(1'b0, 4, 1'b0);
        wr_cnt(1'b0, 9, 1'b1);
        meas_a_rise(n); chk("R11 zero takes old shadow", n, 4);
        pulse_zero();
        meas_a_rise(n); chk("R11 new value at next zero", n, 9);
        red_shadow_en = 1'b0;
    endtask

    task automatic t_complementary();
        int n;
        wr_cnt(1'b0, 3, 1'b0);
        wr_cnt(1'b1, 2, 1'b0);
        fed_inv = 1'b1;
        @(negedge clk); pwm_a_in = 1'b0;
        repeat (4) @(negedge clk);
        pwm_a_in = 1'b1; #1;
        chk("R10 B drops at rising edge", int'(gate_b), 0);
        chk("R10 A still low", int'(gate_a), 0);
        count_until(1'b0, 1'b1, n);
        chk("R10 gap after rising edge", n, 3);
        repeat (2) @(negedge clk);
        pwm_a_in = 1'b0; #1;
        chk("R10 A drops at falling edge", int'(gate_a), 0);
        chk("R10 B still low", int'(gate_b), 0);
        count_until(1'b1, 1'b1, n);
        chk("R10 gap after falling edge", n, 2);
        fed_inv = 1'b0;
    endtask

    initial begin
        t_reset();
        t_red();
        t_fed();
        t_swallow();
        t_tick_stall();
        t_bypass();
        t_pol_enabled();
        t_shadow();
        t_complementary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule